// File: doc/BRIEF.md
# Presence-Tracked Structure Memory Bank

This block is one bank of 16-bit storage cells shared by a group of dataflow processing elements. Every cell carries a presence bit next to its data, so it is either EMPTY or FULL. Processing elements send request tokens that name an operation, a cell, up to two operands and a return tag. The bank sends back result tokens that carry the same tag, so the network can route each result to the node that asked for it.

A read that finds its cell EMPTY does not fail and does not return stale data. It is parked in a short waiting list for the bank. The first operation that fills that cell answers every parked reader of that cell, oldest first. Read-increment, read-decrement and compare-and-swap each change a cell in a single step and return the cell's previous value as a token. The bank takes at most one request per cycle and handles requests strictly in the order they arrive. Cells are given their starting values by ordinary write requests issued before the program's readers run.

Top module: `istruct_bank`

## Requirements
- R1: A read (opcode 0) of a FULL cell at `req_addr` returns that cell's stored value on `rsp_data`, with `rsp_tag` equal to the request's tag.
- R2: A write (opcode 1) with `req_imm`=1 stores `req_left` at `req_addr`. With `req_imm`=0 it stores `req_right` at the cell named by `req_left[ADDR_W-1:0]` and ignores `req_addr`. In both cases the cell becomes FULL. Writes and clears never produce a response of their own.
- R3: A clear (opcode 2) makes the cell EMPTY. A read of that cell afterwards produces no response until the cell is filled again.
- R4: Read-increment (opcode 3) and read-decrement (opcode 4) return the old value and store old+1 or old-1 modulo 2^16. Decrementing 0x0000 stores 0xFFFF.
- R5: Compare-and-swap (opcode 5) returns the old value. It stores `req_right` only when the old value equals `req_left`; otherwise the cell is unchanged.
- R6: An atomic operation (opcodes 3, 4 and 5) on an EMPTY cell treats the old value as 0. It returns 0, and any value it stores leaves the cell FULL.
- R7: Up to DEFER_DEPTH reads of EMPTY cells wait in the bank. When a cell is filled, every waiting reader of that cell receives the stored value with its own tag, in the order the reads arrived. Readers of other cells keep waiting.
- R8: A read of an EMPTY cell that arrives while DEFER_DEPTH reads are already waiting is held inside the bank, and `req_ready` stays low until the bank is reset.
- R9: A write (opcode 1) to a FULL cell replaces the data and sets `err_overwrite`. The flag stays set until reset.
- R10: Responses leave in request order. While `rsp_ready` is low, a pending response keeps `rsp_valid`, `rsp_data` and `rsp_tag` unchanged.
- R11: After reset every cell is EMPTY, the waiting list is empty, `rsp_valid` and `err_overwrite` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request token present |
| req_ready | output | 1 | Bank accepts the request this cycle |
| req_op | input | 3 | Operation code (0 read, 1 write, 2 clear, 3 read-increment, 4 read-decrement, 5 compare-and-swap) |
| req_imm | input | 1 | Write only: 1 takes the cell from `req_addr` and the data from `req_left` |
| req_addr | input | ADDR_W | Immediate cell address |
| req_left | input | DATA_W | Left operand |
| req_right | input | DATA_W | Right operand |
| req_tag | input | TAG_W | Return destination, echoed in the response |
| rsp_valid | output | 1 | Response token present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DATA_W | Result value |
| rsp_tag | output | TAG_W | Return destination of the result |
| err_overwrite | output | 1 | Sticky flag: a write hit a FULL cell |

## Verification
The bench builds the bank with ADDR_W=4, which gives a 16-cell bank. This lets a dyadic write carry junk in the upper bits of its left operand and still prove that only the low four bits choose the cell. DEFER_DEPTH is set to 3, so three parked reads fill the waiting list and a fourth reaches the held state within a few requests. Two parked readers on the same cell, separated by a reader of another cell, show the release order and that only the filled cell's readers are answered. TAG_W stays at 8, so every response tag in a run can be distinct.

// File: rtl/istruct_pkg.sv
package istruct_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_CLEAR = 3'd2,
    OP_RDINC = 3'd3,
    OP_RDDEC = 3'd4,
    OP_CAS   = 3'd5
  } op_e;

endpackage

// File: rtl/istruct_ram.sv
module istruct_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual port, read-first: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/istruct_alu.sv
module istruct_alu
  import istruct_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic              imm,
  input  logic [DATA_W-1:0] old_val,
  input  logic [DATA_W-1:0] left,
  input  logic [DATA_W-1:0] right,
  output logic              wr,
  output logic [DATA_W-1:0] new_val,
  output logic              replies
);

  always_comb begin
    wr      = 1'b0;
    new_val = old_val;
    replies = 1'b0;
    case (op)
      OP_READ:  replies = 1'b1;
      OP_WRITE: begin
        wr      = 1'b1;
        new_val = imm ? left : right;
      end
      OP_RDINC: begin
        wr      = 1'b1;
        new_val = old_val + DATA_W'(1);
        replies = 1'b1;
      end
      OP_RDDEC: begin
        wr      = 1'b1;
        new_val = old_val - DATA_W'(1);
        replies = 1'b1;
      end
      OP_CAS: begin
        wr      = (old_val == left);
        new_val = right;
        replies = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/istruct_defer.sv
module istruct_defer #(
  parameter int ADDR_W = 6,
  parameter int TAG_W  = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq,
  input  logic [ADDR_W-1:0] enq_addr,
  input  logic [TAG_W-1:0]  enq_tag,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              pop,
  output logic              full,
  output logic              q_any,
  output logic              q_multi,
  output logic [TAG_W-1:0]  q_tag
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [TAG_W-1:0]  e_tag  [DEPTH];
  logic [DEPTH-1:0]  hit;
  logic [IDX_W-1:0]  first;
  logic              do_pop;

  // Entries are kept packed from index 0, oldest first.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_hit
    assign hit[gi] = (CNT_W'(gi) < cnt) && (e_addr[gi] == q_addr);
  end

  always_comb begin
    first = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) first = IDX_W'(i);
    end
  end

  assign q_any   = |hit;
  assign q_multi = $countones(hit) > 1;
  assign q_tag   = e_tag[first];
  assign full    = (cnt == CNT_W'(DEPTH));
  assign do_pop  = pop && q_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (enq) begin
      cnt <= cnt + CNT_W'(1);
    end else if (do_pop) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // Removing entry k shifts every younger entry down by one place.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    if (gi < DEPTH - 1) begin : g_mid
      always_ff @(posedge clk) begin
        if (enq && CNT_W'(gi) == cnt) begin
          e_addr[gi] <= enq_addr;
          e_tag[gi]  <= enq_tag;
        end else if (do_pop && IDX_W'(gi) >= first) begin
          e_addr[gi] <= e_addr[gi+1];
          e_tag[gi]  <= e_tag[gi+1];
        end
      end
    end else begin : g_last
      always_ff @(posedge clk) begin
        if (enq && CNT_W'(gi) == cnt) begin
          e_addr[gi] <= enq_addr;
          e_tag[gi]  <= enq_tag;
        end
      end
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    enq |-> !full);

  p_pop_hits_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> q_any);

  p_enq_pop_apart_r7: assert property (@(posedge clk) disable iff (rst)
    enq |-> !pop);

  p_pop_shrinks_r7: assert property (@(posedge clk) disable iff (rst)
    do_pop |=> !full);

endmodule

// File: rtl/istruct_bank.sv
module istruct_bank
  import istruct_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int TAG_W       = 8,
  parameter int DEFER_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic              req_imm,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_left,
  input  logic [DATA_W-1:0] req_right,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              err_overwrite
);

  localparam int CELLS = 1 << ADDR_W;

  // Execute stage holding one accepted request.
  logic              s1_v;
  op_e               s1_op;
  logic              s1_imm;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_left;
  logic [DATA_W-1:0] s1_right;
  logic [TAG_W-1:0]  s1_tag;

  logic [CELLS-1:0]  full_q;

  // Bypass of the write made at the edge the RAM was read.
  logic              wb_v;
  logic [ADDR_W-1:0] wb_a;
  logic [DATA_W-1:0] wb_d;

  // Release of parked readers after a fill.
  logic              rel_active;
  logic [ADDR_W-1:0] rel_addr;
  logic [DATA_W-1:0] rel_data;

  logic              accept;
  op_e               in_op;
  logic [ADDR_W-1:0] in_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] ram_word;
  logic              cur_full;
  logic [DATA_W-1:0] old_val;
  logic              alu_wr;
  logic [DATA_W-1:0] alu_new;
  logic              alu_replies;
  logic              is_read;
  logic              park;
  logic              slot_free;
  logic              fire;
  logic              mem_we;
  logic              emit;
  logic              rel_go;
  logic [ADDR_W-1:0] q_addr;
  logic              d_full;
  logic              d_any;
  logic              d_multi;
  logic [TAG_W-1:0]  d_tag;

  assign in_op   = op_e'(req_op);
  assign in_addr = (in_op == OP_WRITE && !req_imm) ? req_left[ADDR_W-1:0] : req_addr;
  assign accept  = req_valid && req_ready;
  assign rd_addr = accept ? in_addr : s1_addr;

  assign ram_word = (wb_v && wb_a == s1_addr) ? wb_d : rd_q;
  assign cur_full = full_q[s1_addr];
  assign old_val  = cur_full ? ram_word : '0;

  assign is_read   = (s1_op == OP_READ);
  assign park      = is_read && !cur_full;
  assign slot_free = !rsp_valid || rsp_ready;
  assign fire      = s1_v && !rel_active && slot_free && !(park && d_full);
  assign req_ready = !s1_v || fire;
  assign mem_we    = fire && alu_wr;
  assign emit      = fire && alu_replies && !park;
  assign rel_go    = rel_active && slot_free;
  assign q_addr    = rel_active ? rel_addr : s1_addr;

  istruct_ram #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ram (
    .clk     (clk),
    .wr_en   (mem_we),
    .wr_addr (s1_addr),
    .wr_data (alu_new),
    .rd_addr (rd_addr),
    .rd_data (rd_q)
  );

  istruct_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op      (s1_op),
    .imm     (s1_imm),
    .old_val (old_val),
    .left    (s1_left),
    .right   (s1_right),
    .wr      (alu_wr),
    .new_val (alu_new),
    .replies (alu_replies)
  );

  istruct_defer #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W),
    .DEPTH  (DEFER_DEPTH)
  ) u_defer (
    .clk      (clk),
    .rst      (rst),
    .enq      (fire && park),
    .enq_addr (s1_addr),
    .enq_tag  (s1_tag),
    .q_addr   (q_addr),
    .pop      (rel_go),
    .full     (d_full),
    .q_any    (d_any),
    .q_multi  (d_multi),
    .q_tag    (d_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v     <= 1'b0;
      s1_op    <= OP_READ;
      s1_imm   <= 1'b0;
      s1_addr  <= '0;
      s1_left  <= '0;
      s1_right <= '0;
      s1_tag   <= '0;
    end else if (accept) begin
      s1_v     <= 1'b1;
      s1_op    <= in_op;
      s1_imm   <= req_imm;
      s1_addr  <= in_addr;
      s1_left  <= req_left;
      s1_right <= req_right;
      s1_tag   <= req_tag;
    end else if (fire) begin
      s1_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q        <= '0;
      err_overwrite <= 1'b0;
    end else if (fire) begin
      if (mem_we) full_q[s1_addr] <= 1'b1;
      if (s1_op == OP_CLEAR) full_q[s1_addr] <= 1'b0;
      if (s1_op == OP_WRITE && cur_full) err_overwrite <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_v <= 1'b0;
      wb_a <= '0;
      wb_d <= '0;
    end else begin
      wb_v <= mem_we;
      wb_a <= s1_addr;
      wb_d <= alu_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_active <= 1'b0;
      rel_addr   <= '0;
      rel_data   <= '0;
    end else if (rel_active) begin
      if (rel_go && !d_multi) rel_active <= 1'b0;
    end else if (mem_we && d_any) begin
      rel_active <= 1'b1;
      rel_addr   <= s1_addr;
      rel_data   <= alu_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_tag   <= '0;
    end else if (rel_go) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rel_data;
      rsp_tag   <= d_tag;
    end else if (emit) begin
      rsp_valid <= 1'b1;
      rsp_data  <= old_val;
      rsp_tag   <= s1_tag;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_overwrite |=> err_overwrite);

  p_clear_empties_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && s1_op == OP_CLEAR) |=> !full_q[$past(s1_addr)]);

  p_fill_marks_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> full_q[$past(s1_addr)]);

  p_release_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (rel_active && s1_v) |-> !req_ready);

  p_reset_idle_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!rsp_valid && !err_overwrite && req_ready));

endmodule

// File: tb/istruct_bank_tb.sv
module istruct_bank_tb;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int TW = 8;
  localparam int DD = 3;
  localparam int NV = 22;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [2:0]    req_op = '0;
  logic          req_imm = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_left = '0;
  logic [DW-1:0] req_right = '0;
  logic [TW-1:0] req_tag = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [DW-1:0] rsp_data;
  logic [TW-1:0] rsp_tag;
  logic          err_overwrite;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] rx_d [256];
  logic [TW-1:0] rx_t [256];
  int            rx_n = 0;

  always #10 clk = ~clk;

  istruct_bank #(
    .DATA_W      (DW),
    .ADDR_W      (AW),
    .TAG_W       (TW),
    .DEFER_DEPTH (DD)
  ) u_dut (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_imm       (req_imm),
    .req_addr      (req_addr),
    .req_left      (req_left),
    .req_right     (req_right),
    .req_tag       (req_tag),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_tag       (rsp_tag),
    .err_overwrite (err_overwrite)
  );

  // Inputs change at negedge+1; the monitor samples at negedge+2.
  always @(negedge clk) begin
    #2;
    if (!rst && rsp_valid && rsp_ready) begin
      rx_d[rx_n[7:0]] = rsp_data;
      rx_t[rx_n[7:0]] = rsp_tag;
      rx_n++;
    end
  end

  // Fields: req, op, imm, addr, left, right, tag, expect, data, expected tag
  typedef struct packed {
    logic [3:0]    rq;
    logic [2:0]    op;
    logic          imm;
    logic [AW-1:0] addr;
    logic [DW-1:0] left;
    logic [DW-1:0] right;
    logic [TW-1:0] tag;
    logic          exp;
    logic [DW-1:0] data;
    logic [TW-1:0] etag;
  } vec_t;

  localparam logic [76:0] VEC [NV] = '{
    {4'd2, 3'd1, 1'b1, 4'd2,  16'h1234, 16'h0000, 8'h01, 1'b0, 16'h0000, 8'h00}, // R2 imm write
    {4'd1, 3'd0, 1'b0, 4'd2,  16'h0000, 16'h0000, 8'h11, 1'b1, 16'h1234, 8'h11}, // R1 read
    {4'd2, 3'd1, 1'b0, 4'd12, 16'hFF35, 16'hBEEF, 8'h02, 1'b0, 16'h0000, 8'h00}, // R2 dyadic write
    {4'd2, 3'd0, 1'b0, 4'd5,  16'h0000, 16'h0000, 8'h12, 1'b1, 16'hBEEF, 8'h12}, // R2 readback
    {4'd4, 3'd3, 1'b0, 4'd2,  16'h0000, 16'h0000, 8'h13, 1'b1, 16'h1234, 8'h13}, // R4 inc
    {4'd4, 3'd0, 1'b0, 4'd2,  16'h0000, 16'h0000, 8'h14, 1'b1, 16'h1235, 8'h14}, // R4
    {4'd4, 3'd4, 1'b0, 4'd2,  16'h0000, 16'h0000, 8'h15, 1'b1, 16'h1235, 8'h15}, // R4 dec
    {4'd4, 3'd0, 1'b0, 4'd2,  16'h0000, 16'h0000, 8'h16, 1'b1, 16'h1234, 8'h16}, // R4
    {4'd4, 3'd1, 1'b1, 4'd7,  16'h0000, 16'h0000, 8'h03, 1'b0, 16'h0000, 8'h00}, // R4 setup
    {4'd4, 3'd4, 1'b0, 4'd7,  16'h0000, 16'h0000, 8'h17, 1'b1, 16'h0000, 8'h17}, // R4 dec of 0
    {4'd4, 3'd0, 1'b0, 4'd7,  16'h0000, 16'h0000, 8'h18, 1'b1, 16'hFFFF, 8'h18}, // R4 wrap
    {4'd5, 3'd5, 1'b0, 4'd2,  16'h1234, 16'h0777, 8'h19, 1'b1, 16'h1234, 8'h19}, // R5 match
    {4'd5, 3'd0, 1'b0, 4'd2,  16'h0000, 16'h0000, 8'h1A, 1'b1, 16'h0777, 8'h1A}, // R5
    {4'd5, 3'd5, 1'b0, 4'd2,  16'h1111, 16'h9999, 8'h1B, 1'b1, 16'h0777, 8'h1B}, // R5 mismatch
    {4'd5, 3'd0, 1'b0, 4'd2,  16'h0000, 16'h0000, 8'h1C, 1'b1, 16'h0777, 8'h1C}, // R5 unchanged
    {4'd3, 3'd2, 1'b0, 4'd5,  16'h0000, 16'h0000, 8'h04, 1'b0, 16'h0000, 8'h00}, // R3 clear
    {4'd3, 3'd0, 1'b0, 4'd5,  16'h0000, 16'h0000, 8'h20, 1'b0, 16'h0000, 8'h00}, // R3 parked
    {4'd7, 3'd1, 1'b1, 4'd5,  16'h4242, 16'h0000, 8'h05, 1'b1, 16'h4242, 8'h20}, // R7 release
    {4'd6, 3'd3, 1'b0, 4'd9,  16'h0000, 16'h0000, 8'h21, 1'b1, 16'h0000, 8'h21}, // R6 inc empty
    {4'd6, 3'd0, 1'b0, 4'd9,  16'h0000, 16'h0000, 8'h22, 1'b1, 16'h0001, 8'h22}, // R6
    {4'd6, 3'd5, 1'b0, 4'd10, 16'h0000, 16'h0055, 8'h23, 1'b1, 16'h0000, 8'h23}, // R6 cas empty
    {4'd6, 3'd0, 1'b0, 4'd10, 16'h0000, 16'h0000, 8'h24, 1'b1, 16'h0055, 8'h24}  // R6
  };

  task automatic chk(input string rq, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [2:0] op, input logic imm, input logic [AW-1:0] addr,
                      input logic [DW-1:0] l, input logic [DW-1:0] r,
                      input logic [TW-1:0] tag);
    @(negedge clk);
    #1;
    req_op = op; req_imm = imm; req_addr = addr;
    req_left = l; req_right = r; req_tag = tag;
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    @(negedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst = 1'b1;
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog: actual hung run expected completion");
    finish_run();
  end

  initial begin
    int base;
    vec_t v;
    do_reset();

    // R11 reset state
    chk("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R11", "req_ready", 32'(req_ready), 32'd1);
    chk("R11", "err_overwrite", 32'(err_overwrite), 32'd0);

    for (int i = 0; i < NV; i++) begin
      v = vec_t'(VEC[i]);
      base = rx_n;
      send(v.op, v.imm, v.addr, v.left, v.right, v.tag);
      wait_cyc(6);
      if (v.exp) begin
        chk($sformatf("R%0d", v.rq), $sformatf("vec %0d count", i), 32'(rx_n), 32'(base + 1));
        chk($sformatf("R%0d", v.rq), $sformatf("vec %0d data", i), 32'(rx_d[base[7:0]]), 32'(v.data));
        chk($sformatf("R%0d", v.rq), $sformatf("vec %0d tag", i), 32'(rx_t[base[7:0]]), 32'(v.etag));
      end else begin
        chk($sformatf("R%0d", v.rq), $sformatf("vec %0d silent", i), 32'(rx_n), 32'(base));
      end
    end
    chk("R9", "flag clear after first fills", 32'(err_overwrite), 32'd0);

    // R9 overwrite of a FULL cell
    send(3'd1, 1'b1, 4'd2, 16'hAAAA, 16'h0, 8'h30);
    wait_cyc(4);
    chk("R9", "flag after overwrite", 32'(err_overwrite), 32'd1);
    base = rx_n;
    send(3'd0, 1'b0, 4'd2, 16'h0, 16'h0, 8'h31);
    wait_cyc(4);
    chk("R9", "overwritten data", 32'(rx_d[base[7:0]]), 32'h0000AAAA);
    send(3'd2, 1'b0, 4'd2, 16'h0, 16'h0, 8'h32);
    send(3'd1, 1'b1, 4'd2, 16'hBBBB, 16'h0, 8'h33);
    wait_cyc(4);
    chk("R9", "flag sticky", 32'(err_overwrite), 32'd1);

    // R10 backpressure and order
    rsp_ready = 1'b0;
    base = rx_n;
    send(3'd0, 1'b0, 4'd2, 16'h0, 16'h0, 8'h40);
    send(3'd0, 1'b0, 4'd9, 16'h0, 16'h0, 8'h41);
    wait_cyc(3);
    chk("R10", "held valid", 32'(rsp_valid), 32'd1);
    chk("R10", "held data", 32'(rsp_data), 32'h0000BBBB);
    wait_cyc(4);
    chk("R10", "stable tag", 32'(rsp_tag), 32'h40);
    rsp_ready = 1'b1;
    wait_cyc(5);
    chk("R10", "count", 32'(rx_n), 32'(base + 2));
    chk("R10", "first tag", 32'(rx_t[base[7:0]]), 32'h40);
    chk("R10", "second tag", 32'(rx_t[8'(base + 1)]), 32'h41);
    chk("R10", "second data", 32'(rx_d[8'(base + 1)]), 32'h1);

    // R7 release order across two cells
    do_reset();
    base = rx_n;
    send(3'd0, 1'b0, 4'd3, 16'h0, 16'h0, 8'hA1);
    send(3'd0, 1'b0, 4'd4, 16'h0, 16'h0, 8'hB1);
    send(3'd0, 1'b0, 4'd3, 16'h0, 16'h0, 8'hA2);
    wait_cyc(4);
    chk("R7", "parked silent", 32'(rx_n), 32'(base));
    send(3'd1, 1'b1, 4'd3, 16'h3333, 16'h0, 8'h50);
    wait_cyc(8);
    chk("R7", "released count", 32'(rx_n), 32'(base + 2));
    chk("R7", "oldest tag", 32'(rx_t[base[7:0]]), 32'hA1);
    chk("R7", "next tag", 32'(rx_t[8'(base + 1)]), 32'hA2);
    chk("R7", "released data", 32'(rx_d[8'(base + 1)]), 32'h3333);
    send(3'd1, 1'b1, 4'd4, 16'h4444, 16'h0, 8'h51);
    wait_cyc(6);
    chk("R7", "other cell tag", 32'(rx_t[8'(base + 2)]), 32'hB1);
    chk("R7", "other cell data", 32'(rx_d[8'(base + 2)]), 32'h4444);

    // R8 waiting list full
    do_reset();
    send(3'd0, 1'b0, 4'd1, 16'h0, 16'h0, 8'h61);
    send(3'd0, 1'b0, 4'd2, 16'h0, 16'h0, 8'h62);
    send(3'd0, 1'b0, 4'd3, 16'h0, 16'h0, 8'h63);
    send(3'd0, 1'b0, 4'd4, 16'h0, 16'h0, 8'h64);
    @(negedge clk);
    #1;
    req_op = 3'd1; req_imm = 1'b1; req_addr = 4'd1; req_left = 16'h7777;
    req_valid = 1'b1;
    wait_cyc(8);
    chk("R8", "ready held low", 32'(req_ready), 32'd0);
    req_valid = 1'b0;
    do_reset();
    chk("R11", "ready after reset", 32'(req_ready), 32'd1);

    finish_run();
  end

endmodule